// File: doc/BRIEF.md
# Overlapped Tower-Sum Peak Finder

This block searches one tile of calorimeter trigger data for isolated energy deposits. The tile is a grid of 8-bit sums in eta (rows) and phi (columns). Each sum already covers a 2x2 group of towers. Around the grid sits a band of border cells copied from neighbouring regions. At every core cell the block adds a 2x2 group of adjacent input sums. This forms an overlapped 4x4 tower sum, so there is one such sum for each core cell. A core cell becomes a peak when its sum reaches a programmable threshold and it also beats all eight of its neighbouring sums. The comparison against the neighbours is asymmetric, so a plateau of equal sums yields a single peak.

At most four peaks are reported in each tile, strongest first. Each reported peak carries a 6-bit position address and a 10-bit energy. The path is fully pipelined: a new tile may be presented on every clock. Results appear after a fixed number of cycles with an accompanying valid strobe.

Top module: `iso_peak_finder`

## Requirements
- R1: The 4x4 sum of core cell (e,p) is the sum of the four input cells at padded rows e+1 and e+2 and padded columns p+1 and p+2. It is carried in 10 bits without loss; the largest possible value is 1020.
- R2: The input grid has 11 padded rows and 11 padded columns. Padded rows 0 and 1 and padded columns 0 and 1 are border cells on the low side. Padded row 10 and padded column 10 are border cells on the high side. Core cell (e,p) sits at padded (e+2,p+2). Cell (r,c) occupies `tile_in[(r*11+c)*8 +: 8]`.
- R3: A core cell can be a peak only if its 4x4 sum is greater than or equal to `thresh`. A sum exactly equal to the threshold qualifies.
- R4: Some neighbours of a candidate are compared with greater-or-equal: the three neighbours at eta-1, and the neighbour at the same eta and phi-1. The other four neighbours must be strictly smaller than the candidate. As a result, a uniform tile produces no peak.
- R5: Two adjacent core cells are never both reported. A plateau of equal sums gives exactly one peak, located at the plateau's highest eta and, within that eta, its highest phi.
- R6: At most four peaks are reported in a tile. They are placed in slots 0 to 3 in order of non-increasing energy, and the filled slots form a contiguous run starting at slot 0. Slot k uses `peak_valid[k]`, `peak_addr[k*6 +: 6]` and `peak_energy[k*10 +: 10]`.
- R7: When two reported peaks have equal energy, the one with the lower address occupies the lower slot.
- R8: A peak's address is eta in bits 5:3 and phi in bits 2:0. Its energy is its 4x4 sum.
- R9: A slot without a peak has `peak_valid` low, and its address and energy are zero.
- R10: The result of a tile presented with `in_valid` high appears, with `out_valid` high, 6 clock edges later. Tiles may arrive on consecutive cycles.
- R11: While `rst` is asserted, every output is driven to zero.
- R12: Border cells are never reported themselves. Their sums still take part in the neighbour comparison, so a large border sum suppresses an adjacent core cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one tile per cycle |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Tile on `tile_in` is valid |
| tile_in | input | 968 | 11x11 padded grid of 8-bit 2x2 sums |
| thresh | input | 10 | Peak threshold on the 4x4 sum |
| out_valid | output | 1 | Peak slots hold a tile result |
| peak_valid | output | 4 | Per-slot peak present |
| peak_addr | output | 24 | Per-slot 6-bit eta/phi address |
| peak_energy | output | 40 | Per-slot 10-bit energy |

## Verification
The bench places isolated deposits on the tile, so each one spreads into a 2x2 plateau of equal overlapped sums. A design that applied the strict and non-strict comparisons the same way would report none or several of the plateau cells, or a cell displaced by one position. Threshold-equal sums, uniform tiles and border cells taller than the core are driven directly, which catches off-by-one threshold logic and misaligned padding. Five peaks of distinct energy, and several peaks of equal energy, expose faults in the ranking, in the truncation to four slots and in the address tie order. Long back-to-back random tiles reveal any latency slip or state leaking from one tile into the next.

// File: rtl/peak_find_pkg.sv
package peak_find_pkg;

    localparam int TOWER_W  = 8;
    localparam int SUM_W    = 10;
    localparam int ETA_N    = 8;
    localparam int PHI_N    = 8;
    localparam int PAD_LO   = 2;
    localparam int PAD_HI   = 1;
    localparam int ROWS     = ETA_N + PAD_LO + PAD_HI;
    localparam int COLS     = PHI_N + PAD_LO + PAD_HI;
    localparam int GRID_R   = ROWS - 1;
    localparam int GRID_C   = COLS - 1;
    localparam int ETA_AW   = $clog2(ETA_N);
    localparam int PHI_AW   = $clog2(PHI_N);
    localparam int ADDR_W   = ETA_AW + PHI_AW;
    localparam int NCELL    = ETA_N * PHI_N;
    localparam int IDX_W    = $clog2(NCELL);
    localparam int N_PEAKS  = 4;
    localparam int LATENCY  = 2 + N_PEAKS;

    typedef logic [SUM_W-1:0] sum_t;

    typedef struct packed {
        logic             vld;
        logic [IDX_W-1:0] idx;
    } slot_t;

    // Position address of a flat core index: eta in upper bits, phi in lower.
    function automatic logic [ADDR_W-1:0] cell_addr(input int idx);
        return ADDR_W'(((idx / PHI_N) << PHI_AW) | (idx % PHI_N));
    endfunction

    // Neighbour test: non-strict toward the low side, strict toward the high side.
    function automatic logic beats(input sum_t c, input sum_t n, input logic low_side);
        return low_side ? (c >= n) : (c > n);
    endfunction

endpackage

// File: rtl/pf_sum_stage.sv
module pf_sum_stage
    import peak_find_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          vld_i,
    input  logic [ROWS*COLS*TOWER_W-1:0]  tile_i,
    input  sum_t                          thr_i,
    output logic                          vld_o,
    output sum_t                          thr_o,
    output sum_t [GRID_R*GRID_C-1:0]      grid_o
);
    localparam int NG = GRID_R * GRID_C;

    sum_t [NG-1:0] grid_d;

    function automatic sum_t tw(input int r, input int c);
        return sum_t'(tile_i[(r*COLS + c)*TOWER_W +: TOWER_W]);
    endfunction

    // Grid entry (gx,gy) covers padded rows gx..gx+1 and columns gy..gy+1.
    for (genvar gx = 0; gx < GRID_R; gx++) begin : g_row
        for (genvar gy = 0; gy < GRID_C; gy++) begin : g_col
            assign grid_d[gx*GRID_C + gy] = tw(gx, gy) + tw(gx+1, gy)
                                          + tw(gx, gy+1) + tw(gx+1, gy+1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o  <= 1'b0;
            thr_o  <= '0;
            grid_o <= '0;
        end else begin
            vld_o  <= vld_i;
            thr_o  <= thr_i;
            grid_o <= grid_d;
        end
    end

endmodule

// File: rtl/pf_iso_stage.sv
module pf_iso_stage
    import peak_find_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      vld_i,
    input  sum_t                      thr_i,
    input  sum_t [GRID_R*GRID_C-1:0]  grid_i,
    output logic                      vld_o,
    output logic [NCELL-1:0]          flag_o,
    output sum_t [NCELL-1:0]          energy_o
);
    logic [NCELL-1:0] flag_d;
    sum_t [NCELL-1:0] energy_d;

    always_comb begin
        sum_t c;
        logic ok;
        c  = '0;
        ok = 1'b0;
        for (int e = 0; e < ETA_N; e++) begin
            for (int p = 0; p < PHI_N; p++) begin
                c  = grid_i[(e+1)*GRID_C + (p+1)];
                ok = (c >= thr_i);
                for (int de = -1; de <= 1; de++) begin
                    for (int dp = -1; dp <= 1; dp++) begin
                        if (!(de == 0 && dp == 0))
                            ok = ok & beats(c, grid_i[(e+1+de)*GRID_C + (p+1+dp)],
                                            (de < 0) || (de == 0 && dp < 0));
                    end
                end
                flag_d[e*PHI_N + p]   = ok;
                energy_d[e*PHI_N + p] = c;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o    <= 1'b0;
            flag_o   <= '0;
            energy_o <= '0;
        end else begin
            vld_o    <= vld_i;
            flag_o   <= flag_d;
            energy_o <= energy_d;
        end
    end

    // R5: no two adjacent cells can both be flagged as peaks.
    for (genvar e = 0; e < ETA_N; e++) begin : g_chk_e
        for (genvar p = 0; p < PHI_N; p++) begin : g_chk_p
            if (p < PHI_N-1) begin : g_phi
                p_no_adj_phi_r5: assert property (@(posedge clk) disable iff (rst)
                    flag_o[e*PHI_N+p] |-> !flag_o[e*PHI_N+p+1]);
            end
            if (e < ETA_N-1) begin : g_eta
                p_no_adj_eta_r5: assert property (@(posedge clk) disable iff (rst)
                    flag_o[e*PHI_N+p] |-> !flag_o[(e+1)*PHI_N+p]);
            end
            if (e < ETA_N-1 && p < PHI_N-1) begin : g_diag
                p_no_adj_diag_r5: assert property (@(posedge clk) disable iff (rst)
                    flag_o[e*PHI_N+p] |-> !flag_o[(e+1)*PHI_N+p+1]);
            end
        end
    end

endmodule

// File: rtl/pf_rank_stage.sv
module pf_rank_stage
    import peak_find_pkg::*;
#(
    parameter int SLOT   = 0,
    parameter int NPEAK  = N_PEAKS
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    vld_i,
    input  logic [NCELL-1:0]        cand_i,
    input  sum_t [NCELL-1:0]        energy_i,
    input  slot_t [NPEAK-1:0]       slots_i,
    output logic                    vld_o,
    output logic [NCELL-1:0]        cand_o,
    output sum_t [NCELL-1:0]        energy_o,
    output slot_t [NPEAK-1:0]       slots_o
);
    logic              found;
    int                best_i;
    sum_t              best_e;
    logic [NCELL-1:0]  cand_d;
    slot_t [NPEAK-1:0] slots_d;

    // Scan low index first; strict compare keeps the lower index on ties.
    always_comb begin
        found  = 1'b0;
        best_i = 0;
        best_e = '0;
        for (int i = 0; i < NCELL; i++) begin
            if (cand_i[i] && (!found || energy_i[i] > best_e)) begin
                found  = 1'b1;
                best_i = i;
                best_e = energy_i[i];
            end
        end
        cand_d = cand_i;
        if (found)
            cand_d[best_i] = 1'b0;
        slots_d           = slots_i;
        slots_d[SLOT].vld = found;
        slots_d[SLOT].idx = found ? IDX_W'(best_i) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o    <= 1'b0;
            cand_o   <= '0;
            energy_o <= '0;
            slots_o  <= '0;
        end else begin
            vld_o    <= vld_i;
            cand_o   <= cand_d;
            energy_o <= energy_i;
            slots_o  <= slots_d;
        end
    end

    // R6: a filled slot removes exactly one candidate from the pool.
    p_pick_removes_r6: assert property (@(posedge clk) disable iff (rst)
        slots_o[SLOT].vld |-> ($countones(cand_o) + 1 == $past($countones(cand_i))));

    // R6: an empty slot means the pool was already empty.
    p_empty_pool_r6: assert property (@(posedge clk) disable iff (rst)
        !slots_o[SLOT].vld |-> (cand_o == '0));

endmodule

// File: rtl/iso_peak_finder.sv
module iso_peak_finder
    import peak_find_pkg::*;
#(
    parameter int NPEAK = N_PEAKS
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    input  logic [ROWS*COLS*TOWER_W-1:0]  tile_in,
    input  logic [SUM_W-1:0]              thresh,
    output logic                          out_valid,
    output logic [NPEAK-1:0]              peak_valid,
    output logic [NPEAK*ADDR_W-1:0]       peak_addr,
    output logic [NPEAK*SUM_W-1:0]        peak_energy
);
    logic                      s1_vld;
    sum_t                      s1_thr;
    sum_t [GRID_R*GRID_C-1:0]  s1_grid;

    logic                      vld_c    [NPEAK+1];
    logic [NCELL-1:0]          cand_c   [NPEAK+1];
    sum_t [NCELL-1:0]          energy_c [NPEAK+1];
    slot_t [NPEAK-1:0]         slots_c  [NPEAK+1];

    pf_sum_stage u_sum (
        .clk    (clk),
        .rst    (rst),
        .vld_i  (in_valid),
        .tile_i (tile_in),
        .thr_i  (thresh),
        .vld_o  (s1_vld),
        .thr_o  (s1_thr),
        .grid_o (s1_grid)
    );

    pf_iso_stage u_iso (
        .clk      (clk),
        .rst      (rst),
        .vld_i    (s1_vld),
        .thr_i    (s1_thr),
        .grid_i   (s1_grid),
        .vld_o    (vld_c[0]),
        .flag_o   (cand_c[0]),
        .energy_o (energy_c[0])
    );

    assign slots_c[0] = '0;

    for (genvar k = 0; k < NPEAK; k++) begin : g_rank
        pf_rank_stage #(.SLOT(k), .NPEAK(NPEAK)) u_rank (
            .clk      (clk),
            .rst      (rst),
            .vld_i    (vld_c[k]),
            .cand_i   (cand_c[k]),
            .energy_i (energy_c[k]),
            .slots_i  (slots_c[k]),
            .vld_o    (vld_c[k+1]),
            .cand_o   (cand_c[k+1]),
            .energy_o (energy_c[k+1]),
            .slots_o  (slots_c[k+1])
        );
    end

    assign out_valid = vld_c[NPEAK];

    for (genvar k = 0; k < NPEAK; k++) begin : g_out
        assign peak_valid[k] = slots_c[NPEAK][k].vld;
        assign peak_addr[k*ADDR_W +: ADDR_W] = slots_c[NPEAK][k].vld
                ? cell_addr(int'(slots_c[NPEAK][k].idx)) : '0;
        assign peak_energy[k*SUM_W +: SUM_W] = slots_c[NPEAK][k].vld
                ? energy_c[NPEAK][slots_c[NPEAK][k].idx] : '0;
    end

    // Ordering of the reported slots.
    for (genvar k = 0; k < NPEAK-1; k++) begin : g_chk
        p_slot_pack_r6: assert property (@(posedge clk) disable iff (rst)
            (out_valid && peak_valid[k+1]) |-> peak_valid[k]);
        p_slot_order_r6: assert property (@(posedge clk) disable iff (rst)
            (out_valid && peak_valid[k+1]) |->
            (peak_energy[k*SUM_W +: SUM_W] >= peak_energy[(k+1)*SUM_W +: SUM_W]));
        p_tie_addr_r7: assert property (@(posedge clk) disable iff (rst)
            (out_valid && peak_valid[k+1] &&
             peak_energy[k*SUM_W +: SUM_W] == peak_energy[(k+1)*SUM_W +: SUM_W]) |->
            (peak_addr[k*ADDR_W +: ADDR_W] < peak_addr[(k+1)*ADDR_W +: ADDR_W]));
    end

    // R6: if the last slot is empty no peak was left unreported.
    p_drained_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !peak_valid[NPEAK-1]) |-> (cand_c[NPEAK] == '0));

endmodule

// File: tb/tb_iso_peak_finder.sv
module tb_iso_peak_finder;
    import peak_find_pkg::*;

    localparam int NP  = N_PEAKS;
    localparam int LAT = LATENCY;

    logic                         clk = 1'b0;
    logic                         rst = 1'b1;
    logic                         in_valid = 1'b0;
    logic [ROWS*COLS*TOWER_W-1:0] tile_in = '0;
    logic [SUM_W-1:0]             thresh = '0;
    logic                         out_valid;
    logic [NP-1:0]                peak_valid;
    logic [NP*ADDR_W-1:0]         peak_addr;
    logic [NP*SUM_W-1:0]          peak_energy;

    iso_peak_finder dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .tile_in(tile_in),
        .thresh(thresh), .out_valid(out_valid), .peak_valid(peak_valid),
        .peak_addr(peak_addr), .peak_energy(peak_energy)
    );

    always #5 clk = ~clk;

    typedef struct {
        int                   cyc;
        logic [NP-1:0]        v;
        logic [NP*ADDR_W-1:0] a;
        logic [NP*SUM_W-1:0]  e;
        string                tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   tests = 0;
    int   fails = 0;
    int   tl [ROWS][COLS];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic clear_tile();
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) tl[r][c] = 0;
    endtask

    // Expected result built from the requirement text.
    function automatic exp_t model(input int thr, input string tag);
        exp_t x;
        int s [ROWS][COLS];
        bit pk [ETA_N][PHI_N];
        x.v = '0; x.a = '0; x.e = '0; x.tag = tag; x.cyc = 0;
        for (int r = 1; r < ROWS; r++)
            for (int c = 1; c < COLS; c++)
                s[r][c] = tl[r-1][c-1] + tl[r][c-1] + tl[r-1][c] + tl[r][c];
        for (int e = 0; e < ETA_N; e++)
            for (int p = 0; p < PHI_N; p++) begin
                int v;
                bit ok;
                v  = s[e+2][p+2];
                ok = (v >= thr);
                for (int de = -1; de <= 1; de++)
                    for (int dp = -1; dp <= 1; dp++) begin
                        int n;
                        n = s[e+2+de][p+2+dp];
                        if (de < 0 || (de == 0 && dp < 0)) ok = ok && (v >= n);
                        else if (!(de == 0 && dp == 0))     ok = ok && (v > n);
                    end
                pk[e][p] = ok;
            end
        for (int k = 0; k < NP; k++) begin
            int be, bp, bv;
            be = -1; bp = -1; bv = -1;
            for (int e = 0; e < ETA_N; e++)
                for (int p = 0; p < PHI_N; p++)
                    if (pk[e][p] && s[e+2][p+2] > bv) begin
                        be = e; bp = p; bv = s[e+2][p+2];
                    end
            if (be >= 0) begin
                pk[be][bp] = 1'b0;
                x.v[k] = 1'b1;
                x.a[k*ADDR_W +: ADDR_W] = ADDR_W'(be * 8 + bp);
                x.e[k*SUM_W +: SUM_W]   = SUM_W'(bv);
            end
        end
        return x;
    endfunction

    task automatic send(input int thr, input string tag);
        exp_t x;
        x = model(thr, tag);
        @(negedge clk);
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                tile_in[(r*COLS + c)*TOWER_W +: TOWER_W] = TOWER_W'(tl[r][c]);
        thresh   = SUM_W'(thr);
        in_valid = 1'b1;
        x.cyc    = cyc;
        q.push_back(x);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Scoreboard monitor.
    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                if (q.size() == 0) begin
                    check(1'b0, "R10", "unexpected out_valid", 64'd1, 64'd0);
                end else begin
                    exp_t x;
                    x = q.pop_front();
                    check(cyc == x.cyc + LAT, "R10", "latency",
                          64'(cyc - x.cyc), 64'(LAT));
                    check(peak_valid == x.v, x.tag, "peak_valid",
                          64'(peak_valid), 64'(x.v));
                    check(peak_addr == x.a, x.tag, "peak_addr",
                          64'(peak_addr), 64'(x.a));
                    check(peak_energy == x.e, x.tag, "peak_energy",
                          64'(peak_energy), 64'(x.e));
                end
            end else if (q.size() != 0 && cyc >= q[0].cyc + LAT) begin
                check(1'b0, "R10", "missing out_valid", 64'd0, 64'd1);
                void'(q.pop_front());
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        check(1'b0, "WDOG", "watchdog expired", 64'd0, 64'd1);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        clear_tile();
        // R11: reset state
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0 && peak_valid == '0, "R11", "valid in reset",
              64'({out_valid, peak_valid}), 64'd0);
        check(peak_addr == '0 && peak_energy == '0, "R11", "data in reset",
              64'(peak_energy), 64'd0);
        rst = 1'b0;

        // R1 R2 R8: one deposit -> plateau, single peak at its high corner
        clear_tile(); tl[5][5] = 100;
        send(50, "R1_R8");
        // R3: equal to threshold passes
        send(100, "R3");
        // R9: one above threshold -> all slots empty
        send(101, "R9");
        // R5: plateau of equal sums near the low corner
        clear_tile(); tl[3][3] = 60;
        send(1, "R5");
        // R4: uniform tile, nothing wins
        clear_tile();
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) tl[r][c] = 7;
        send(0, "R4");
        // R4: two touching deposits of differing size
        clear_tile(); tl[4][4] = 90; tl[4][5] = 40; tl[7][8] = 30; tl[8][8] = 30;
        send(1, "R4");
        // R6: five separated deposits, only the four largest reported
        clear_tile();
        tl[2][2] = 10; tl[2][8] = 50; tl[5][5] = 30; tl[8][2] = 40; tl[8][8] = 20;
        send(1, "R6");
        // R7: equal deposits ordered by address
        clear_tile(); tl[8][2] = 70; tl[2][8] = 70; tl[5][5] = 70;
        send(1, "R7");
        // R12: tall border cells beside the core
        clear_tile(); tl[0][4] = 250; tl[2][4] = 60; tl[10][6] = 250; tl[9][3] = 20;
        send(1, "R12");
        // R12: border only, no core peak may appear
        clear_tile(); tl[0][0] = 200; tl[10][10] = 200; tl[1][9] = 120;
        send(1, "R12");
        // R1: maximal values do not overflow
        clear_tile();
        for (int r = 3; r < 5; r++)
            for (int c = 3; c < 5; c++) tl[r][c] = 255;
        send(1000, "R1");
        idle();
        repeat (3) @(negedge clk);

        // R10: back-to-back random tiles
        for (int t = 0; t < 60; t++) begin
            for (int r = 0; r < ROWS; r++)
                for (int c = 0; c < COLS; c++)
                    tl[r][c] = ($urandom % 4 == 0) ? int'($urandom % 256) : 0;
            send(int'($urandom % 300), "R10");
        end
        idle();
        repeat (LAT + 4) @(negedge clk);
        check(q.size() == 0, "R10", "scoreboard drained", 64'(q.size()), 64'd0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule